// File: doc/BRIEF.md
# Banked stack pointer switch unit

This unit keeps the live A7 stack pointer together with two banked copies, one for supervisor mode and one for user mode. Writes to the status register, writes to the cache control register and exception entry all request a bank swap. Exception return is an ordinary status register write. On a swap the live A7 is parked in the bank that was active and then reloaded from the bank that the new control state selects. The swap runs on every such write, even when the selection stays the same. In that case A7 comes out unchanged.

The supervisor bank is chosen only when the supervisor bit of the status register and the user-stack enable bit of the cache control register are both set. Any other combination selects the user bank. A direct port lets the move-to-USP and move-from-USP operations reach the user bank. When the user bank is the active one, that port reaches the live A7 instead.

Support for the user stack is chosen at build time with the `HAS_USP` parameter. With it cleared, A7 is never banked and the user-stack port does nothing.

Top module: `sp_bank_switch`

## Requirements
- R1: After reset:
  - sr_o reads 0x2700 and cacr_o reads 0.
  - a7_o and usp_o read 0.
  - active_bank_o reads 1 (user) when HAS_USP=1, and 0 when HAS_USP=0.
- R2: With HAS_USP=1, active_bank_o is 0 (supervisor) exactly when sr_o bit 13 and cacr_o bit 4 are both 1. Otherwise it is 1 (user).
- R3: A cycle with sr_we_i, cacr_we_i or exc_entry_i high is a swap cycle. After the clock edge of a swap cycle:
  - The pre-swap A7 is held in the bank that was active before the edge. The pre-swap A7 is the live A7 after that cycle's direct writes.
  - a7_o holds the bank selected by the new sr_o/cacr_o.
- R4: A swap that selects the bank already active leaves a7_o equal to the pre-swap A7.
- R5: An SR write stores only sr_wdata_i bits 15:8. sr_o bits 7:0 always read 0.
- R6: exc_entry_i sets sr_o bit 13 at the next edge, on top of any SR write in the same cycle, and triggers a swap.
- R7: A cacr_we_i write stores all 32 bits of cacr_wdata_i into cacr_o and triggers a swap.
- R8: a7_we_i loads a7_wdata_i into the live A7 at the next edge, before any swap of that cycle.
- R9: usp_we_i (HAS_USP=1) works as follows:
  - It writes the user bank while the supervisor bank is active.
  - While the user bank is active it writes the live A7 instead, taking priority over a7_we_i in the same cycle.
- R10: usp_o reads the user bank while the supervisor bank is active, and reads the live A7 while the user bank is active.
- R11: With HAS_USP=0:
  - active_bank_o stays 0.
  - usp_o reads 0 and usp_we_i has no effect.
  - Status and cache control writes never change a7_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sr_we_i | input | 1 | Status register write (move-to-SR or exception return) |
| sr_wdata_i | input | 16 | Status register write data |
| exc_entry_i | input | 1 | Exception entry: force supervisor bit and swap |
| cacr_we_i | input | 1 | Cache control register write |
| cacr_wdata_i | input | 32 | Cache control register write data |
| a7_we_i | input | 1 | Live A7 write |
| a7_wdata_i | input | 32 | Live A7 write data |
| usp_we_i | input | 1 | Move-to-USP write |
| usp_wdata_i | input | 32 | Move-to-USP data |
| sr_o | output | 16 | Status register system byte |
| cacr_o | output | 32 | Cache control register |
| a7_o | output | 32 | Live A7 |
| usp_o | output | 32 | Move-from-USP read value |
| active_bank_o | output | 1 | Active bank, 0 supervisor, 1 user |

## Verification
The assertions assume that any input may toggle on any cycle, so each property excludes the overlaps it cannot resolve from the ports:
- The user-bank reload check skips cycles with a same-cycle move-to-USP.
- The same-bank check skips cycles with a direct A7 or user-stack write.
- The direct-write check skips swap cycles.

The stimulus deliberately drives those overlaps: status, cache control, exception, A7 and user-stack writes land together at random. The reference model in the bench covers the combinations the assertions leave out. Directed sequences first walk both swap directions, a same-bank swap and the move-to-USP redirection. A second instance built with the user stack disabled shares the same inputs.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  typedef enum logic {
    BANK_SUP = 1'b0,
    BANK_USR = 1'b1
  } bank_e;

  localparam int unsigned SR_W          = 16;
  localparam int unsigned SR_SUP_BIT    = 13;
  localparam int unsigned CACR_USPE_BIT = 4;
  localparam logic [15:0] SR_RESET      = 16'h2700;
  localparam logic [15:0] SR_SYS_MASK   = 16'hFF00;
  localparam int unsigned NUM_BANKS     = 2;
endpackage

// File: rtl/sp_ctrl_regs.sv
module sp_ctrl_regs
  import sp_bank_pkg::*;
#(
  parameter int unsigned CACR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_we_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  input  logic              exc_entry_i,
  input  logic              cacr_we_i,
  input  logic [CACR_W-1:0] cacr_wdata_i,
  output logic [SR_W-1:0]   sr_q_o,
  output logic [CACR_W-1:0] cacr_q_o,
  output logic [SR_W-1:0]   sr_nxt_o,
  output logic [CACR_W-1:0] cacr_nxt_o,
  output logic              swap_o
);
  logic [SR_W-1:0]   sr_q;
  logic [CACR_W-1:0] cacr_q;

  always_comb begin
    sr_nxt_o = sr_q;
    if (sr_we_i) sr_nxt_o = sr_wdata_i & SR_SYS_MASK;
    if (exc_entry_i) sr_nxt_o[SR_SUP_BIT] = 1'b1;
    cacr_nxt_o = cacr_we_i ? cacr_wdata_i : cacr_q;
  end

  // any control write re-runs the swap, even with no mode change
  assign swap_o = sr_we_i | cacr_we_i | exc_entry_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= SR_RESET;
      cacr_q <= '0;
    end else begin
      sr_q   <= sr_nxt_o;
      cacr_q <= cacr_nxt_o;
    end
  end

  assign sr_q_o   = sr_q;
  assign cacr_q_o = cacr_q;
endmodule

// File: rtl/sp_bank_sel.sv
module sp_bank_sel
  import sp_bank_pkg::*;
#(
  parameter bit          HAS_USP = 1'b1,
  parameter int unsigned CACR_W  = 32
) (
  input  logic [SR_W-1:0]   sr_i,
  input  logic [CACR_W-1:0] cacr_i,
  output bank_e             bank_o
);
  generate
    if (HAS_USP) begin : g_sel
      assign bank_o = (sr_i[SR_SUP_BIT] && cacr_i[CACR_USPE_BIT]) ? BANK_SUP : BANK_USR;
    end else begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^{sr_i, cacr_i};
      assign bank_o     = BANK_SUP;
    end
  endgenerate
endmodule

// File: rtl/sp_bank_file.sv
module sp_bank_file
  import sp_bank_pkg::*;
#(
  parameter bit          HAS_USP = 1'b1,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  bank_e             new_bank_i,
  input  logic              a7_we_i,
  input  logic [DATA_W-1:0] a7_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  output logic [DATA_W-1:0] a7_o,
  output logic [DATA_W-1:0] usp_o,
  output bank_e             cur_o
);
  localparam bank_e CUR_RST = HAS_USP ? BANK_USR : BANK_SUP;

  logic [DATA_W-1:0] bank_q   [NUM_BANKS];
  logic [DATA_W-1:0] bank_pre [NUM_BANKS];
  logic [DATA_W-1:0] a7_q, a7_pre, a7_nxt;
  bank_e             cur_q;
  logic              swap_eff;
  logic              usp_hit_live;

  assign swap_eff     = swap_i & HAS_USP;
  assign usp_hit_live = HAS_USP && usp_we_i && (cur_q == BANK_USR);

  // direct writes land first, the swap then sees their result
  always_comb begin
    a7_pre = a7_we_i ? a7_wdata_i : a7_q;
    if (usp_hit_live) a7_pre = usp_wdata_i;
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      if (g == int'(BANK_USR)) begin : g_usr
        always_comb begin
          bank_pre[g] = bank_q[g];
          if (HAS_USP && usp_we_i && (cur_q == BANK_SUP)) bank_pre[g] = usp_wdata_i;
        end
      end else begin : g_sup
        assign bank_pre[g] = bank_q[g];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q[g] <= '0;
        else if (swap_eff && (int'(cur_q) == g)) bank_q[g] <= a7_pre;
        else bank_q[g] <= bank_pre[g];
      end
    end
  endgenerate

  always_comb begin
    a7_nxt = a7_pre;
    if (swap_eff && (new_bank_i != cur_q)) a7_nxt = bank_pre[new_bank_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a7_q  <= '0;
      cur_q <= CUR_RST;
    end else begin
      a7_q <= a7_nxt;
      if (swap_eff) cur_q <= new_bank_i;
    end
  end

  assign a7_o  = a7_q;
  assign cur_o = cur_q;

  generate
    if (HAS_USP) begin : g_usp_rd
      assign usp_o = (cur_q == BANK_USR) ? a7_q : bank_q[BANK_USR];
    end else begin : g_usp_none
      assign usp_o = '0;
    end
  endgenerate
endmodule

// File: rtl/sp_bank_switch.sv
module sp_bank_switch
  import sp_bank_pkg::*;
#(
  parameter bit          HAS_USP = 1'b1,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CACR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_we_i,
  input  logic [15:0]       sr_wdata_i,
  input  logic              exc_entry_i,
  input  logic              cacr_we_i,
  input  logic [CACR_W-1:0] cacr_wdata_i,
  input  logic              a7_we_i,
  input  logic [DATA_W-1:0] a7_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  output logic [15:0]       sr_o,
  output logic [CACR_W-1:0] cacr_o,
  output logic [DATA_W-1:0] a7_o,
  output logic [DATA_W-1:0] usp_o,
  output logic              active_bank_o
);
  logic [SR_W-1:0]   sr_nxt;
  logic [CACR_W-1:0] cacr_nxt;
  logic              swap;
  bank_e             new_bank;
  bank_e             cur_bank;

  sp_ctrl_regs #(.CACR_W(CACR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sr_we_i     (sr_we_i),
    .sr_wdata_i  (sr_wdata_i),
    .exc_entry_i (exc_entry_i),
    .cacr_we_i   (cacr_we_i),
    .cacr_wdata_i(cacr_wdata_i),
    .sr_q_o      (sr_o),
    .cacr_q_o    (cacr_o),
    .sr_nxt_o    (sr_nxt),
    .cacr_nxt_o  (cacr_nxt),
    .swap_o      (swap)
  );

  sp_bank_sel #(.HAS_USP(HAS_USP), .CACR_W(CACR_W)) u_sel (
    .sr_i  (sr_nxt),
    .cacr_i(cacr_nxt),
    .bank_o(new_bank)
  );

  sp_bank_file #(.HAS_USP(HAS_USP), .DATA_W(DATA_W)) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .swap_i     (swap),
    .new_bank_i (new_bank),
    .a7_we_i    (a7_we_i),
    .a7_wdata_i (a7_wdata_i),
    .usp_we_i   (usp_we_i),
    .usp_wdata_i(usp_wdata_i),
    .a7_o       (a7_o),
    .usp_o      (usp_o),
    .cur_o      (cur_bank)
  );

  assign active_bank_o = cur_bank;
endmodule

// File: rtl/sp_bank_switch_chk.sv
module sp_bank_switch_chk #(
  parameter bit          HAS_USP = 1'b1,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CACR_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sr_we_i,
  input logic              exc_entry_i,
  input logic              cacr_we_i,
  input logic              a7_we_i,
  input logic [DATA_W-1:0] a7_wdata_i,
  input logic              usp_we_i,
  input logic [15:0]       sr_o,
  input logic [CACR_W-1:0] cacr_o,
  input logic [DATA_W-1:0] a7_o,
  input logic [DATA_W-1:0] usp_o,
  input logic              active_bank_o
);
  logic swap_ev;
  assign swap_ev = sr_we_i | cacr_we_i | exc_entry_i;

  p_bank_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    HAS_USP |-> (active_bank_o == !(sr_o[13] && cacr_o[4])));

  p_user_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_USP && $rose(active_bank_o) && !$past(usp_we_i)) |-> (a7_o == $past(usp_o)));

  p_same_bank_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_USP && $past(swap_ev) && $stable(active_bank_o) && !$past(a7_we_i) && !$past(usp_we_i))
      |-> $stable(a7_o));

  p_sr_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[7:0] == 8'h00);

  p_exc_sets_sup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exc_entry_i) |-> sr_o[13]);

  p_a7_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(a7_we_i) && !$past(usp_we_i) && !$past(swap_ev)) |-> (a7_o == $past(a7_wdata_i)));

  p_no_usp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_USP |-> (!active_bank_o && (usp_o == '0)));
endmodule

bind sp_bank_switch sp_bank_switch_chk #(
  .HAS_USP(HAS_USP), .DATA_W(DATA_W), .CACR_W(CACR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sr_we_i      (sr_we_i),
  .exc_entry_i  (exc_entry_i),
  .cacr_we_i    (cacr_we_i),
  .a7_we_i      (a7_we_i),
  .a7_wdata_i   (a7_wdata_i),
  .usp_we_i     (usp_we_i),
  .sr_o         (sr_o),
  .cacr_o       (cacr_o),
  .a7_o         (a7_o),
  .usp_o        (usp_o),
  .active_bank_o(active_bank_o)
);

// File: tb/sp_bank_switch_tb.sv
`timescale 1ns/1ps
module sp_bank_switch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_we = 0, exc = 0, cacr_we = 0, a7_we = 0, usp_we = 0;
  logic [15:0] sr_wd = '0;
  logic [31:0] cacr_wd = '0, a7_wd = '0, usp_wd = '0;

  logic [15:0] sr_o   [2];
  logic [31:0] cacr_o [2];
  logic [31:0] a7_o   [2];
  logic [31:0] usp_o  [2];
  logic        bank_o [2];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_sr   [2];
  logic [31:0] m_cacr [2];
  logic [31:0] m_b0   [2];
  logic [31:0] m_b1   [2];
  logic [31:0] m_a7   [2];
  logic        m_cur  [2];

  always #10 clk = ~clk;

  sp_bank_switch #(.HAS_USP(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .exc_entry_i(exc),
    .cacr_we_i(cacr_we), .cacr_wdata_i(cacr_wd), .a7_we_i(a7_we), .a7_wdata_i(a7_wd),
    .usp_we_i(usp_we), .usp_wdata_i(usp_wd), .sr_o(sr_o[0]), .cacr_o(cacr_o[0]),
    .a7_o(a7_o[0]), .usp_o(usp_o[0]), .active_bank_o(bank_o[0]));

  sp_bank_switch #(.HAS_USP(1'b0)) u_dut_nousp (
    .clk_i(clk), .rst_ni(rst_n), .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .exc_entry_i(exc),
    .cacr_we_i(cacr_we), .cacr_wdata_i(cacr_wd), .a7_we_i(a7_we), .a7_wdata_i(a7_wd),
    .usp_we_i(usp_we), .usp_wdata_i(usp_wd), .sr_o(sr_o[1]), .cacr_o(cacr_o[1]),
    .a7_o(a7_o[1]), .usp_o(usp_o[1]), .active_bank_o(bank_o[1]));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < 2; k++) begin
      m_sr[k] = 16'h2700; m_cacr[k] = 0; m_b0[k] = 0; m_b1[k] = 0; m_a7[k] = 0;
      m_cur[k] = (k == 0);
    end
  endfunction

  function automatic void model_step(int k, bit has);
    logic [31:0] a7p, b0p, b1p, cn;
    logic [15:0] srn;
    logic nsel;
    srn = m_sr[k];
    if (sr_we) srn = sr_wd & 16'hFF00;
    if (exc) srn = srn | 16'h2000;
    cn  = cacr_we ? cacr_wd : m_cacr[k];
    a7p = a7_we ? a7_wd : m_a7[k];
    b0p = m_b0[k];
    b1p = m_b1[k];
    if (has && usp_we) begin
      if (m_cur[k]) a7p = usp_wd; else b1p = usp_wd;
    end
    if (has && (sr_we || cacr_we || exc)) begin
      nsel = !(srn[13] && cn[4]);
      if (m_cur[k]) b1p = a7p; else b0p = a7p;
      if (nsel != m_cur[k]) a7p = nsel ? b1p : b0p;
      m_cur[k] = nsel;
    end
    m_sr[k] = srn; m_cacr[k] = cn; m_a7[k] = a7p; m_b0[k] = b0p; m_b1[k] = b1p;
  endfunction

  always @(posedge clk) if (rst_n) begin
    model_step(0, 1'b1);
    model_step(1, 1'b0);
  end

  task automatic compare_all();
    for (int k = 0; k < 2; k++) begin
      check("R5 sr", {16'h0, sr_o[k]}, {16'h0, m_sr[k]});
      check("R7 cacr", cacr_o[k], m_cacr[k]);
      check(k == 0 ? "R3 a7" : "R11 a7", a7_o[k], m_a7[k]);
      check(k == 0 ? "R2 bank" : "R11 bank", {31'h0, bank_o[k]}, {31'h0, m_cur[k]});
      check(k == 0 ? "R10 usp" : "R11 usp", usp_o[k], (k == 0) ? (m_cur[k] ? m_a7[k] : m_b1[k]) : 32'h0);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    sr_we = 0; exc = 0; cacr_we = 0; a7_we = 0; usp_we = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sr", {16'h0, sr_o[0]}, 32'h2700);
    check("R1 cacr", cacr_o[0], 0);
    check("R1 a7", a7_o[0], 0);
    check("R1 usp", usp_o[0], 0);
    check("R1 bank", {31'h0, bank_o[0]}, 1);
    check("R1 bank nousp", {31'h0, bank_o[1]}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    a7_we = 1; a7_wd = 32'h1111_0000; tick();
    check("R8 a7 write", a7_o[0], 32'h1111_0000);
    cacr_we = 1; cacr_wd = 32'h0000_0010; tick();           // S=1 & enable -> supervisor
    check("R3 to sup a7", a7_o[0], 32'h0);
    check("R2 sup bank", {31'h0, bank_o[0]}, 0);
    check("R3 saved user", usp_o[0], 32'h1111_0000);
    check("R11 a7 unswitched", a7_o[1], 32'h1111_0000);
    a7_we = 1; a7_wd = 32'hAAAA_0000; tick();
    sr_we = 1; sr_wd = 16'h2000; tick();                     // same selection
    check("R4 same bank", a7_o[0], 32'hAAAA_0000);
    usp_we = 1; usp_wd = 32'h5555_0000; tick();
    check("R9 usp to bank", usp_o[0], 32'h5555_0000);
    check("R9 a7 untouched", a7_o[0], 32'hAAAA_0000);
    check("R11 usp ignored", usp_o[1], 0);
    sr_we = 1; sr_wd = 16'h0000; tick();                     // -> user
    check("R3 to user a7", a7_o[0], 32'h5555_0000);
    usp_we = 1; usp_wd = 32'h7777_0000; a7_we = 1; a7_wd = 32'h1234_5678; tick();
    check("R9 usp to live a7", a7_o[0], 32'h7777_0000);
    sr_we = 1; sr_wd = 16'h00FF; tick();
    check("R5 low byte dropped", {16'h0, sr_o[0]}, 32'h0);
    sr_we = 1; sr_wd = 16'h0700; exc = 1; tick();
    check("R6 exc sets S", {16'h0, sr_o[0]}, 32'h2700);
    check("R6 exc swap a7", a7_o[0], 32'hAAAA_0000);
    check("R10 usp after exc", usp_o[0], 32'h7777_0000);
    cacr_we = 1; cacr_wd = 32'hDEAD_BEEF; tick();
    check("R7 cacr full", cacr_o[0], 32'hDEAD_BEEF);

    for (int i = 0; i < 3000; i++) begin
      sr_we   = ($urandom % 4) == 0;
      sr_wd   = 16'($urandom);
      exc     = ($urandom % 16) == 0;
      cacr_we = ($urandom % 5) == 0;
      cacr_wd = $urandom;
      a7_we   = ($urandom % 3) == 0;
      a7_wd   = $urandom;
      usp_we  = ($urandom % 4) == 0;
      usp_wd  = $urandom;
      tick();
    end
    done = 1;
    finish_run();
  end
endmodule